// File: doc/BRIEF.md
# Descriptor-chained DMA channel

This block is one DMA channel. It copies data words from a source address to a destination address. Its work comes from descriptors held in memory. It reads a descriptor through its memory master port and then waits for a peripheral request. For each request it makes one read and one write, and it steps both addresses as the descriptor's address controls ask. When the buffer ends it closes that buffer. Closing can raise an interrupt, capture status from the peripheral and move the descriptor pointer on. The channel then fetches the next descriptor unless the descriptor told it to stop.

Software loads the descriptor pointer and pulses `start` while the channel is idle. The channel has two modes. In chained mode, descriptors follow one another: either at a fixed 16-byte stride or by following the link word of each descriptor. In direct mode, a single buffer runs and the channel then returns to idle. This mode also enables a remaining-length watermark interrupt.

The peripheral side has five signals:
- a level request;
- a per-transfer acknowledge;
- an end-of-frame strobe going out;
- an early end-of-frame input;
- a 4-bit command/status exchange.

Top module: `desc_dma_chan`

## Requirements
- R1: After reset `busy`, `m_req`, `irq_eob`, `irq_wm` and `eof_flag` are 0 and `ptr_q` and `cmd_q` are 0.
- R2: A descriptor is four words read with four single reads at `ptr_q`, `ptr_q`+4, `ptr_q`+8 and `ptr_q`+12. Their meanings, in that order, are: source address, destination address, control word, link. The control word fields are: length in bits [15:0], source control [17:16], destination control [19:18], end-of-buffer interrupt enable [20], follow-link [21], EOF enable [22], halt [23], command [27:24] and quad size [28].
- R3: Each address control behaves as follows: 00 holds the address, 01 adds the stride after every transfer, 10 subtracts it, and 11 holds the address like 00. The stride is 4 when the quad bit is set, otherwise 1.
- R4: Each transfer is a read at the source followed by a write of the same data to the destination. Each transfer waits for `p_req`. Each transfer lowers the length by one and is reported by a one-cycle `p_ack`. A buffer of length N makes exactly N transfers.
- R5: In chained mode (`chain_en`=1) the next descriptor pointer depends on the follow-link bit. When it is clear, the pointer is the current pointer plus 16. When it is set, the pointer is the link word. The channel fetches the next descriptor at once unless halt is set.
- R6: With halt set, the channel goes idle after the buffer closes. `ptr_q` then holds the next descriptor address, and that descriptor is not fetched.
- R7: With EOF enable set, `p_eof_out` is high together with `p_ack` on the transfer made while the length is 1, and only then.
- R8: If `p_eof_in` is high when a transfer's write completes, the buffer closes after that transfer and `eof_flag` reads 1.
- R9: `cmd_q` drives `p_cmd`. `p_cmd_vld` is high only during the first transfer of a buffer. `cmd_q` is loaded by `cmd_wr` or by the descriptor's command field.
- R10: When a buffer closes with EOF enable set (from the descriptor or from an early EOF), `cmd_q` captures `p_stat`.
- R11: When a buffer closes with the interrupt enable set, `irq_eob` pulses for one cycle.
- R12: In direct mode (`chain_en`=0) the channel goes idle after one buffer and leaves `ptr_q` unchanged. If the interrupt enable is set, `irq_wm` pulses once when the remaining length falls to `wmark`.
- R13: A descriptor with length 0 closes immediately with no data transfer.
- R14: While `m_req` is high and `m_ack` is low, `m_req`, `m_addr`, `m_we` and `m_wdata` stay unchanged into the next cycle. Only one access is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| chain_en | input | 1 | 1 = chained descriptors, 0 = single buffer |
| wmark | input | LEN_W | Remaining-length watermark for direct mode |
| ptr_wr | input | 1 | Load descriptor pointer (idle only) |
| ptr_wdata | input | AW | Pointer value |
| start | input | 1 | Begin fetching at the pointer (idle only) |
| cmd_wr | input | 1 | Load command/status register |
| cmd_wdata | input | 4 | Command value |
| m_req | output | 1 | Memory access request |
| m_we | output | 1 | 1 = write, 0 = read |
| m_addr | output | AW | Byte address |
| m_wdata | output | DW | Write data |
| m_ack | input | 1 | Access complete |
| m_rdata | input | DW | Read data, valid with m_ack |
| p_req | input | 1 | Peripheral transfer request |
| p_ack | output | 1 | Transfer done strobe |
| p_eof_out | output | 1 | End of frame to peripheral |
| p_eof_in | input | 1 | Early end of frame from peripheral |
| p_cmd | output | 4 | Command to peripheral |
| p_cmd_vld | output | 1 | First transfer of a buffer |
| p_stat | input | 4 | Status from peripheral |
| irq_eob | output | 1 | End-of-buffer interrupt pulse |
| irq_wm | output | 1 | Watermark interrupt pulse |
| busy | output | 1 | Channel active |
| ptr_q | output | AW | Current descriptor pointer |
| cmd_q | output | 4 | Command/status register |
| eof_flag | output | 1 | EOF enable bit of the current buffer |

## Verification
The bench builds the channel with its default parameters: 32-bit addresses and data, a 16-bit length and quad strides enabled. With these, every address control can be tried at both the 1-byte and the 4-byte stride. The 16-byte chaining step and the link-following path land on small, separate descriptor areas of the bench memory. Lengths stay short, so the full close sequence can be reached in every test: early EOF, halt, a zero-length buffer and the direct-mode watermark.

// File: rtl/desc_dma_pkg.sv
package desc_dma_pkg;

   typedef enum logic [2:0] {
      ST_IDLE, ST_FETCH, ST_WAIT, ST_READ, ST_WRITE, ST_CLOSE
   } st_e;

   typedef enum logic [1:0] {
      AC_FIXED = 2'b00,
      AC_INC   = 2'b01,
      AC_DEC   = 2'b10,
      AC_RSVD  = 2'b11
   } actl_e;

   // control bits sitting just above the length field, LSB first: sctl
   typedef struct packed {
      logic       quad;
      logic [3:0] cmd;
      logic       halt;
      logic       eof_en;
      logic       follow;
      logic       ieob;
      logic [1:0] dctl;
      logic [1:0] sctl;
   } ctl_t;

   localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/desc_dma_step.sv
module desc_dma_step
   import desc_dma_pkg::*;
#(
   parameter int AW         = 32,
   parameter bit ALLOW_QUAD = 1'b1
) (
   input  logic [AW-1:0] cur,
   input  logic [1:0]    mode,
   input  logic          quad,
   output logic [AW-1:0] nxt
);
   localparam logic [AW-1:0] STEP_ONE  = AW'(1);
   localparam logic [AW-1:0] STEP_QUAD = AW'(4);

   logic [AW-1:0] stride;

   generate
      if (ALLOW_QUAD) begin : g_quad
         assign stride = quad ? STEP_QUAD : STEP_ONE;
      end else begin : g_unit
         logic unused_quad;
         assign unused_quad = quad;
         assign stride      = STEP_ONE;
      end
   endgenerate

   always_comb begin
      case (actl_e'(mode))
         AC_INC:  nxt = cur + stride;
         AC_DEC:  nxt = cur - stride;
         default: nxt = cur;   // fixed and reserved both hold
      endcase
   end

endmodule

// File: rtl/desc_dma_link.sv
module desc_dma_link #(
   parameter int AW         = 32,
   parameter int DESC_BYTES = 16
) (
   input  logic [AW-1:0] ptr,
   input  logic [AW-1:0] link,
   input  logic          follow,
   output logic [AW-1:0] nxt
);
   localparam logic [AW-1:0] STRIDE = AW'(DESC_BYTES);

   assign nxt = follow ? link : ptr + STRIDE;

endmodule

// File: rtl/desc_dma_chan.sv
module desc_dma_chan
   import desc_dma_pkg::*;
#(
   parameter int AW         = 32,
   parameter int DW         = 32,
   parameter int LEN_W      = 16,
   parameter bit ALLOW_QUAD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chain_en,
   input  logic [LEN_W-1:0] wmark,
   input  logic             ptr_wr,
   input  logic [AW-1:0]    ptr_wdata,
   input  logic             start,
   input  logic             cmd_wr,
   input  logic [3:0]       cmd_wdata,
   output logic             m_req,
   output logic             m_we,
   output logic [AW-1:0]    m_addr,
   output logic [DW-1:0]    m_wdata,
   input  logic             m_ack,
   input  logic [DW-1:0]    m_rdata,
   input  logic             p_req,
   output logic             p_ack,
   output logic             p_eof_out,
   input  logic             p_eof_in,
   output logic [3:0]       p_cmd,
   output logic             p_cmd_vld,
   input  logic [3:0]       p_stat,
   output logic             irq_eob,
   output logic             irq_wm,
   output logic             busy,
   output logic [AW-1:0]    ptr_q,
   output logic [3:0]       cmd_q,
   output logic             eof_flag
);
   localparam int WORD_BYTES = DW / 8;
   localparam int WB_SH      = $clog2(WORD_BYTES);
   localparam int DESC_WORDS = 4;
   localparam int DESC_BYTES = DESC_WORDS * WORD_BYTES;
   localparam int FIDX_W     = $clog2(DESC_WORDS);
   localparam logic [FIDX_W-1:0] FIDX_LAST = FIDX_W'(DESC_WORDS - 1);
   localparam logic [LEN_W-1:0]  LEN_ONE   = LEN_W'(1);
   localparam logic [LEN_W-1:0]  LEN_ZERO  = '0;

   initial begin
      a_cfg_ctl_fits: assert (DW >= LEN_W + CTL_W)
         else $error("control word does not fit in DW");
      a_cfg_addr_fits: assert (AW <= DW && DW % 8 == 0)
         else $error("address or data width unsupported");
   end

   st_e                st;
   logic [FIDX_W-1:0]  fidx;
   logic [AW-1:0]      ptr, src, dst, link, ptr_nxt;
   logic [LEN_W-1:0]   len, len_dec;
   ctl_t               ctl, ctl_in;
   logic [DW-1:0]      buf_q;
   logic               first;
   logic [3:0]         cmd_r;
   logic               xfer_done;
   logic               unused_cmd;

   logic [AW-1:0]      cur_a [2];
   logic [AW-1:0]      nxt_a [2];
   logic [1:0]         mode_a [2];

   assign ctl_in     = ctl_t'(m_rdata[LEN_W +: CTL_W]);
   assign xfer_done  = (st == ST_WRITE) && m_ack;
   assign len_dec    = len - LEN_ONE;
   assign unused_cmd = ^ctl.cmd;

   assign cur_a[0]  = src;
   assign cur_a[1]  = dst;
   assign mode_a[0] = ctl.sctl;
   assign mode_a[1] = ctl.dctl;

   generate
      for (genvar g = 0; g < 2; g++) begin : g_step
         desc_dma_step #(.AW(AW), .ALLOW_QUAD(ALLOW_QUAD)) u_step (
            .cur  (cur_a[g]),
            .mode (mode_a[g]),
            .quad (ctl.quad),
            .nxt  (nxt_a[g])
         );
      end
   endgenerate

   desc_dma_link #(.AW(AW), .DESC_BYTES(DESC_BYTES)) u_link (
      .ptr    (ptr),
      .link   (link),
      .follow (ctl.follow),
      .nxt    (ptr_nxt)
   );

   // memory master: every output comes from registers, so it holds until ack
   always_comb begin
      m_req = 1'b0;
      m_we  = 1'b0;
      m_addr = '0;
      case (st)
         ST_FETCH: begin
            m_req  = 1'b1;
            m_addr = ptr + (AW'(fidx) << WB_SH);
         end
         ST_READ: begin
            m_req  = 1'b1;
            m_addr = src;
         end
         ST_WRITE: begin
            m_req  = 1'b1;
            m_we   = 1'b1;
            m_addr = dst;
         end
         default: ;
      endcase
   end
   assign m_wdata = buf_q;

   assign p_ack     = xfer_done;
   assign p_eof_out = xfer_done && ctl.eof_en && (len == LEN_ONE);
   assign p_cmd     = cmd_r;
   assign p_cmd_vld = first && ((st == ST_READ) || (st == ST_WRITE));

   assign busy     = (st != ST_IDLE);
   assign ptr_q    = ptr;
   assign cmd_q    = cmd_r;
   assign eof_flag = ctl.eof_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         fidx    <= '0;
         ptr     <= '0;
         src     <= '0;
         dst     <= '0;
         link    <= '0;
         len     <= '0;
         ctl     <= '0;
         buf_q   <= '0;
         first   <= 1'b0;
         cmd_r   <= '0;
         irq_eob <= 1'b0;
         irq_wm  <= 1'b0;
      end else begin
         irq_eob <= 1'b0;
         irq_wm  <= 1'b0;
         if (cmd_wr) cmd_r <= cmd_wdata;
         case (st)
            ST_IDLE: begin
               if (ptr_wr) ptr <= ptr_wdata;
               if (start) begin
                  st   <= ST_FETCH;
                  fidx <= '0;
               end
            end
            ST_FETCH: begin
               if (m_ack) begin
                  if (fidx == FIDX_W'(0)) src <= m_rdata[AW-1:0];
                  if (fidx == FIDX_W'(1)) dst <= m_rdata[AW-1:0];
                  if (fidx == FIDX_W'(2)) begin
                     len   <= m_rdata[LEN_W-1:0];
                     ctl   <= ctl_in;
                     cmd_r <= ctl_in.cmd;
                  end
                  if (fidx == FIDX_LAST) begin
                     link  <= m_rdata[AW-1:0];
                     first <= 1'b1;
                     st    <= (len == LEN_ZERO) ? ST_CLOSE : ST_WAIT;
                  end
                  fidx <= fidx + FIDX_W'(1);
               end
            end
            ST_WAIT: begin
               if (p_req) st <= ST_READ;
            end
            ST_READ: begin
               if (m_ack) begin
                  buf_q <= m_rdata;
                  st    <= ST_WRITE;
               end
            end
            ST_WRITE: begin
               if (m_ack) begin
                  src    <= nxt_a[0];
                  dst    <= nxt_a[1];
                  len    <= len_dec;
                  first  <= 1'b0;
                  irq_wm <= !chain_en && ctl.ieob && (len_dec == wmark);
                  if ((len == LEN_ONE) || p_eof_in) begin
                     st <= ST_CLOSE;
                     if (p_eof_in) ctl.eof_en <= 1'b1;
                  end else begin
                     st <= ST_WAIT;
                  end
               end
            end
            ST_CLOSE: begin
               irq_eob <= ctl.ieob;
               if (ctl.eof_en) cmd_r <= p_stat;
               if (chain_en) begin
                  ptr  <= ptr_nxt;
                  fidx <= '0;
                  st   <= ctl.halt ? ST_IDLE : ST_FETCH;
               end else begin
                  st <= ST_IDLE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R14: request and its qualifiers hold until acknowledged
   a_r14_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_we) && $stable(m_wdata)));

   // R7: EOF to the peripheral marks the last transfer, so the buffer closes next
   a_r7_eof_then_close: assert property (@(posedge clk) disable iff (!rst_n)
      p_eof_out |=> (st == ST_CLOSE));

   // R6: a halted buffer leaves the channel idle after closing
   a_r6_halt_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_CLOSE && ctl.halt) |=> !busy);

   // R11: end-of-buffer interrupt only follows a close
   a_r11_eob_after_close: assert property (@(posedge clk) disable iff (!rst_n)
      irq_eob |-> $past(st == ST_CLOSE));

   // R9: command valid is not repeated after a transfer completes
   a_r9_cmd_once: assert property (@(posedge clk) disable iff (!rst_n)
      p_ack |=> !p_cmd_vld);

endmodule

// File: tb/sim_desc_dma_chan.sv
module sim_desc_dma_chan;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [9:0] s;
      logic [9:0] d;
      logic [1:0] sc;
      logic [1:0] dc;
      logic       q;
      logic [7:0] n;
   } vec_t;

   localparam vec_t VECS [0:5] = '{
      '{10'h010, 10'h200, 2'b01, 2'b01, 1'b0, 8'd4},
      '{10'h020, 10'h210, 2'b00, 2'b01, 1'b1, 8'd3},
      '{10'h040, 10'h22C, 2'b10, 2'b10, 1'b1, 8'd4},
      '{10'h050, 10'h230, 2'b01, 2'b00, 1'b0, 8'd5},
      '{10'h060, 10'h240, 2'b11, 2'b01, 1'b0, 8'd3},
      '{10'h070, 10'h250, 2'b01, 2'b11, 1'b1, 8'd2}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chain_en = 1'b1;
   logic [15:0] wmark = '0;
   logic        ptr_wr = 1'b0;
   logic [31:0] ptr_wdata = '0;
   logic        start = 1'b0;
   logic        cmd_wr = 1'b0;
   logic [3:0]  cmd_wdata = '0;
   logic        m_req, m_we, m_ack;
   logic [31:0] m_addr, m_wdata, m_rdata;
   logic        p_req = 1'b1;
   logic        p_eof_in = 1'b0;
   logic [3:0]  p_stat = '0;
   logic        p_ack, p_eof_out, p_cmd_vld, irq_eob, irq_wm, busy, eof_flag;
   logic [3:0]  p_cmd, cmd_q;
   logic [31:0] ptr_q;

   always #(CLK_PERIOD/2) clk = ~clk;

   desc_dma_chan u0 (
      .clk(clk), .rst_n(rst_n), .chain_en(chain_en), .wmark(wmark),
      .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata), .start(start),
      .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
      .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
      .m_ack(m_ack), .m_rdata(m_rdata),
      .p_req(p_req), .p_ack(p_ack), .p_eof_out(p_eof_out), .p_eof_in(p_eof_in),
      .p_cmd(p_cmd), .p_cmd_vld(p_cmd_vld), .p_stat(p_stat),
      .irq_eob(irq_eob), .irq_wm(irq_wm), .busy(busy), .ptr_q(ptr_q),
      .cmd_q(cmd_q), .eof_flag(eof_flag)
   );

   function automatic logic [31:0] pat(input logic [9:0] a);
      return 32'hC0DE_0000 | {22'b0, a};
   endfunction

   function automatic logic [31:0] ctlw(input int n, input logic [1:0] sc, input logic [1:0] dc,
                                        input bit ie, input bit fl, input bit ef, input bit ht,
                                        input logic [3:0] cm, input bit q);
      return {3'b0, q, cm, ht, ef, fl, ie, dc, sc, n[15:0]};
   endfunction

   // memory model: one access at a time, ack one cycle after request
   logic [31:0] mem [0:1023];
   logic        pl_we = 1'b0;
   logic [9:0]  pl_addr = '0;
   logic [31:0] pl_data = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 1024; i++) mem[i] <= pat(i[9:0]);
         m_ack   <= 1'b0;
         m_rdata <= '0;
      end else begin
         m_ack <= 1'b0;
         if (pl_we) mem[pl_addr] <= pl_data;
         if (m_req && !m_ack) begin
            m_ack <= 1'b1;
            if (m_we) mem[m_addr[9:0]] <= m_wdata;
            else      m_rdata <= mem[m_addr[9:0]];
         end
      end
   end

   // monitor
   logic        mon_clr = 1'b0;
   int          n_ack, n_eofo, eof_at, n_cmdv, n_eob, n_wm, n_rd, hold_err;
   logic [3:0]  cmd_seen;
   logic        hold_pend;
   logic [31:0] hold_addr, hold_wd;
   logic        hold_we;

   always @(posedge clk) begin
      if (!rst_n) begin
         hold_err  <= 0;
         hold_pend <= 1'b0;
      end else begin
         if (hold_pend && (!m_req || m_addr != hold_addr || m_we != hold_we || m_wdata != hold_wd))
            hold_err <= hold_err + 1;
         hold_pend <= m_req && !m_ack;
      end
      hold_addr <= m_addr;
      hold_we   <= m_we;
      hold_wd   <= m_wdata;
      if (mon_clr || !rst_n) begin
         n_ack <= 0; n_eofo <= 0; eof_at <= -1; n_cmdv <= 0;
         n_eob <= 0; n_wm <= 0; n_rd <= 0; cmd_seen <= '0;
      end else begin
         if (p_ack) n_ack <= n_ack + 1;
         if (p_eof_out) begin
            n_eofo <= n_eofo + 1;
            eof_at <= n_ack;
         end
         if (p_cmd_vld && p_ack) begin
            n_cmdv   <= n_cmdv + 1;
            cmd_seen <= p_cmd;
         end
         if (irq_eob) n_eob <= n_eob + 1;
         if (irq_wm)  n_wm  <= n_wm + 1;
         if (m_req && m_ack && !m_we) n_rd <= n_rd + 1;
      end
   end

   int n_chk = 0;
   int n_fail = 0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic poke(input logic [9:0] a, input logic [31:0] d);
      @(negedge clk);
      pl_we = 1'b1; pl_addr = a; pl_data = d;
      @(negedge clk);
      pl_we = 1'b0;
   endtask

   task automatic put_desc(input logic [9:0] base, input logic [31:0] s, input logic [31:0] d,
                           input logic [31:0] w2, input logic [31:0] lk);
      poke(base, s);
      poke(base + 10'd4, d);
      poke(base + 10'd8, w2);
      poke(base + 10'd12, lk);
   endtask

   task automatic launch(input logic [31:0] p);
      @(negedge clk);
      mon_clr = 1'b1; ptr_wr = 1'b1; ptr_wdata = p;
      @(negedge clk);
      mon_clr = 1'b0; ptr_wr = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic finish_run();
      for (int t = 0; t < 4000 && busy; t++) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 busy", 32'(busy), 32'd0);
      check("R1 m_req", 32'(m_req), 32'd0);
      check("R1 irq", 32'({irq_eob, irq_wm, eof_flag}), 32'd0);
      check("R1 ptr_q", ptr_q, 32'd0);
      check("R1 cmd_q", 32'(cmd_q), 32'd0);

      // R9 register load of command
      @(negedge clk); cmd_wr = 1'b1; cmd_wdata = 4'h9;
      @(negedge clk); cmd_wr = 1'b0;
      check("R9 cmd_wr", 32'(cmd_q), 32'h9);

      // vector table: address controls, strides, lengths
      foreach (VECS[v]) begin
         put_desc(10'h300, 32'(VECS[v].s), 32'(VECS[v].d),
                  ctlw(int'(VECS[v].n), VECS[v].sc, VECS[v].dc, 0, 0, 0, 1, 4'h0, VECS[v].q), 32'h0);
         launch(32'h300);
         finish_run();
         check("R4 transfer count", 32'(n_ack), 32'(VECS[v].n));
         check("R2 read count", 32'(n_rd), 32'(VECS[v].n) + 32'd4);
         check("R6 halt ptr", ptr_q, 32'h310);
         for (int i = 0; i < int'(VECS[v].n); i++) begin
            int st_b;
            int sa;
            int da;
            st_b = VECS[v].q ? 4 : 1;
            sa = int'(VECS[v].s);
            da = int'(VECS[v].d);
            if (VECS[v].sc == 2'b01) sa = sa + i * st_b;
            if (VECS[v].sc == 2'b10) sa = sa - i * st_b;
            if (VECS[v].dc == 2'b01) da = da + i * st_b;
            if (VECS[v].dc == 2'b10) da = da - i * st_b;
            if (VECS[v].dc == 2'b01 || VECS[v].dc == 2'b10 || i == int'(VECS[v].n) - 1)
               check("R3 dest word", mem[da[9:0]], pat(sa[9:0]));
         end
      end

      // R5 chaining: stride step, then link follow, then halt
      put_desc(10'h300, 32'h080, 32'h260, ctlw(2, 2'b01, 2'b01, 1, 0, 0, 0, 4'h0, 0), 32'h3F0);
      put_desc(10'h310, 32'h090, 32'h270, ctlw(1, 2'b01, 2'b01, 1, 1, 0, 0, 4'h0, 0), 32'h340);
      put_desc(10'h340, 32'h0A0, 32'h280, ctlw(1, 2'b01, 2'b01, 1, 0, 0, 1, 4'h0, 0), 32'h3F0);
      launch(32'h300);
      finish_run();
      check("R5 chained transfers", 32'(n_ack), 32'd4);
      check("R5 descriptor reads", 32'(n_rd), 32'd16);
      check("R6 pointer after halt", ptr_q, 32'h350);
      check("R11 eob irq count", 32'(n_eob), 32'd3);
      check("R12 no watermark in chained", 32'(n_wm), 32'd0);
      check("R5 first buffer data", mem[10'h261], pat(10'h081));
      check("R5 linked buffer data", mem[10'h280], pat(10'h0A0));

      // R7 EOF on last transfer, R10 status capture, R9 command export, R4 request gating
      p_stat = 4'hA;
      put_desc(10'h300, 32'h0B0, 32'h290, ctlw(3, 2'b01, 2'b01, 1, 0, 1, 1, 4'h5, 0), 32'h0);
      p_req = 1'b0;
      launch(32'h300);
      repeat (20) @(negedge clk);
      check("R4 no transfer without request", 32'(n_ack), 32'd0);
      check("R4 waiting busy", 32'(busy), 32'd1);
      p_req = 1'b1;
      finish_run();
      check("R7 eof count", 32'(n_eofo), 32'd1);
      check("R7 eof on last", 32'(eof_at), 32'd2);
      check("R9 cmd on first", 32'(cmd_seen), 32'h5);
      check("R9 cmd valid once", 32'(n_cmdv), 32'd1);
      check("R10 status captured", 32'(cmd_q), 32'hA);
      check("R11 single eob", 32'(n_eob), 32'd1);

      // R8 early EOF from peripheral
      p_stat = 4'h6;
      put_desc(10'h300, 32'h0C0, 32'h2A0, ctlw(10, 2'b01, 2'b01, 0, 0, 0, 1, 4'h3, 0), 32'h0);
      launch(32'h300);
      wait (n_ack == 2);
      @(negedge clk);
      p_eof_in = 1'b1;
      finish_run();
      p_eof_in = 1'b0;
      check("R8 early close count", 32'(n_ack), 32'd3);
      check("R8 eof flag", 32'(eof_flag), 32'd1);
      check("R10 status after early eof", 32'(cmd_q), 32'h6);
      check("R8 last data", mem[10'h2A2], pat(10'h0C2));

      // R13 zero length
      put_desc(10'h300, 32'h0E0, 32'h2E0, ctlw(0, 2'b01, 2'b01, 1, 0, 0, 1, 4'h7, 0), 32'h0);
      launch(32'h300);
      finish_run();
      check("R13 no transfer", 32'(n_ack), 32'd0);
      check("R13 closes with irq", 32'(n_eob), 32'd1);
      check("R13 only descriptor reads", 32'(n_rd), 32'd4);
      check("R13 cmd from descriptor", 32'(cmd_q), 32'h7);
      check("R13 idle", 32'(busy), 32'd0);

      // R12 direct mode with watermark
      chain_en = 1'b0;
      wmark = 16'd2;
      put_desc(10'h320, 32'h0D0, 32'h2C0, ctlw(5, 2'b01, 2'b01, 1, 0, 0, 0, 4'h0, 0), 32'h0);
      launch(32'h320);
      finish_run();
      check("R12 watermark once", 32'(n_wm), 32'd1);
      check("R12 transfers", 32'(n_ack), 32'd5);
      check("R12 eob", 32'(n_eob), 32'd1);
      check("R12 pointer kept", ptr_q, 32'h320);
      check("R12 idle", 32'(busy), 32'd0);

      // R14 memory port holds while waiting
      check("R14 hold violations", 32'(hold_err), 32'd0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule